// File: doc/BRIEF.md
# Read Idle Power-Save Detector

This block sits beside the read path of a memory array and decides when the array may rest. While the chip select is active, it compares the read address and the select against their values from the previous clock. If neither has moved for a programmable number of clock cycles, it raises a power-save flag. Logic outside this block uses that flag to gate array sensing down to standby level. Analog gating is not part of this block.

While the flag is high, the array output can no longer be trusted. The block therefore captures the array word at the edge where the flag rises and presents that stored copy on its output. Any address movement brings the live array word back onto the output in the same cycle and drops the flag at the next edge. Any change in select level does the same, and the idle count then starts again from zero. Deselecting the block puts it in standby: the flag is low, the output word is zero, and the idle count does not run.

Top module: `rd_idle_saver`

## Requirements
- R1: After synchronous reset `pwr_save` is 0, and with `chip_sel` low `out_word` is 0.
- R2: Call the clock edge that first samples a new address or select level E0. `pwr_save` stays 0 through edge E(IDLE_CYCLES-1) and becomes 1 after edge E(IDLE_CYCLES), provided the inputs do not move in between.
- R3: With the default polarity (`chip_sel` active high, parameter EN_ACTIVE_LOW = 0), a low `chip_sel` drives `out_word` to 0 in the same cycle and `pwr_save` to 0 at the next edge. While `chip_sel` stays low, `pwr_save` remains 0 however long the inputs are stable.
- R4: If `rd_addr` changes while `pwr_save` is 1, `out_word` shows the live `arr_word` in that same cycle, and `pwr_save` falls at the next edge.
- R5: The word held during power-save equals the `arr_word` value present at the edge where `pwr_save` rises. Changes on `arr_word` while `pwr_save` is 1 do not reach `out_word`.
- R6: While select is active and `pwr_save` is 0, `out_word` follows `arr_word` combinationally.
- R7: A further address change during the idle count restarts the full IDLE_CYCLES interval from the edge that samples it.
- R8: Asserting `chip_sel` counts as a change. The interval of R2 starts at the edge that first samples the select high, even when the address is unchanged.
- R9: A change in a single bit of `rd_addr`, whether the least or the most significant bit, ends power-save.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr | input | ADDR_W | Read address being presented to the array |
| chip_sel | input | 1 | Chip select (active high by default) |
| arr_word | input | DATA_W | Live word from the array sense path |
| pwr_save | output | 1 | High while the array may rest |
| out_word | output | DATA_W | Word returned to the reader |

## Verification
The hardest case to reach from the ports is telling a capture at the flag-rise edge apart from a capture one cycle earlier. The stimulus therefore changes `arr_word` exactly once, at the falling edge just before edge E(IDLE_CYCLES), and then corrupts it again right after the flag rises. Only a capture taken on the correct edge returns the middle value. The restart of the count is reached by issuing a second address change partway through an interval. The bench then checks that the flag stays low for a full fresh interval after that second change.

// File: rtl/ris_pkg.sv
package ris_pkg;

   // Operating state of the idle detector
   typedef enum logic [1:0] {
      ST_OFF   = 2'd0,   // deselected, standby
      ST_WATCH = 2'd1,   // selected, counting idle cycles
      ST_SAVE  = 2'd2    // selected, array resting, output held
   } ris_state_t;

   // Width of a counter able to hold the value lim
   function automatic int ris_cnt_width(input int lim);
      return (lim < 2) ? 1 : $clog2(lim + 1);
   endfunction

endpackage

// File: rtl/ris_chg_det.sv
module ris_chg_det #(
   parameter int ADDR_W        = 20,
   parameter bit EN_ACTIVE_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              sel_i,
   output logic              en_o,
   output logic              chg_o
);

   logic              en_w;
   logic [ADDR_W-1:0] addr_q;
   logic              en_q;

   generate
      if (ADDR_W < 1) begin : g_bad_width
         $error("ris_chg_det: ADDR_W must be at least 1");
      end
      if (EN_ACTIVE_LOW) begin : g_en_low
         assign en_w = ~sel_i;
      end else begin : g_en_high
         assign en_w = sel_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         en_q   <= 1'b0;
      end else begin
         addr_q <= addr_i;
         en_q   <= en_w;
      end
   end

   assign en_o  = en_w;
   assign chg_o = (addr_i != addr_q) || (en_w != en_q);

   // a stable address seen one edge earlier may not report a change
   AST_STABLE_NO_CHG: assert property (@(posedge clk) disable iff (rst)
      (!rst && $stable(addr_i) && $stable(en_w) && !$past(rst)) |-> !chg_o); // R7

endmodule

// File: rtl/ris_idle_tmr.sv
module ris_idle_tmr
   import ris_pkg::*;
#(
   parameter int LIMIT = 20,
   localparam int CNT_W = ris_cnt_width(LIMIT)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr_i,
   output logic             expire_o,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("ris_idle_tmr: LIMIT must be at least 2");
      end
   endgenerate

   always_comb begin
      if (clr_i) begin
         cnt_d = '0;
      end else if (cnt_q == LIM_V) begin
         cnt_d = cnt_q;
      end else begin
         cnt_d = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   assign expire_o = (cnt_d == LIM_V);
   assign cnt_o    = cnt_q;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LIM_V); // R2

   AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
      clr_i |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/ris_word_hold.sv
module ris_word_hold #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap_i,
   input  logic              use_hold_i,
   input  logic              en_i,
   input  logic [DATA_W-1:0] arr_i,
   output logic [DATA_W-1:0] word_o
);

   logic [DATA_W-1:0] hold_q;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("ris_word_hold: DATA_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q <= '0;
      end else if (cap_i) begin
         hold_q <= arr_i;
      end
   end

   always_comb begin
      if (!en_i) begin
         word_o = '0;
      end else if (use_hold_i) begin
         word_o = hold_q;
      end else begin
         word_o = arr_i;
      end
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (use_hold_i && !cap_i) |=> (hold_q == $past(hold_q))); // R5

endmodule

// File: rtl/rd_idle_saver.sv
module rd_idle_saver
   import ris_pkg::*;
#(
   parameter int ADDR_W        = 20,
   parameter int DATA_W        = 16,
   parameter int IDLE_CYCLES   = 20,
   parameter bit EN_ACTIVE_LOW = 1'b0,
   localparam int CNT_W        = ris_cnt_width(IDLE_CYCLES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              chip_sel,
   input  logic [DATA_W-1:0] arr_word,
   output logic              pwr_save,
   output logic [DATA_W-1:0] out_word
);

   ris_state_t       st_q;
   ris_state_t       st_d;
   logic             en_w;
   logic             chg_w;
   logic             clr_w;
   logic             expire_w;
   logic [CNT_W-1:0] cnt_w;
   logic             cap_w;
   logic             use_hold_w;

   generate
      if (IDLE_CYCLES < 2) begin : g_bad_idle
         $error("rd_idle_saver: IDLE_CYCLES must be at least 2");
      end
   endgenerate

   ris_chg_det #(
      .ADDR_W       (ADDR_W),
      .EN_ACTIVE_LOW(EN_ACTIVE_LOW)
   ) u_chg (
      .clk   (clk),
      .rst   (rst),
      .addr_i(rd_addr),
      .sel_i (chip_sel),
      .en_o  (en_w),
      .chg_o (chg_w)
   );

   assign clr_w = !en_w || chg_w;

   ris_idle_tmr #(
      .LIMIT(IDLE_CYCLES)
   ) u_tmr (
      .clk     (clk),
      .rst     (rst),
      .clr_i   (clr_w),
      .expire_o(expire_w),
      .cnt_o   (cnt_w)
   );

   always_comb begin
      st_d = st_q;
      if (!en_w) begin
         st_d = ST_OFF;
      end else if (chg_w) begin
         st_d = ST_WATCH;
      end else if (st_q == ST_WATCH && expire_w) begin
         st_d = ST_SAVE;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q <= ST_OFF;
      end else begin
         st_q <= st_d;
      end
   end

   assign cap_w      = (st_q == ST_WATCH) && (st_d == ST_SAVE);
   assign use_hold_w = (st_q == ST_SAVE) && !chg_w;

   ris_word_hold #(
      .DATA_W(DATA_W)
   ) u_hold (
      .clk       (clk),
      .rst       (rst),
      .cap_i     (cap_w),
      .use_hold_i(use_hold_w),
      .en_i      (en_w),
      .arr_i     (arr_word),
      .word_o    (out_word)
   );

   assign pwr_save = (st_q == ST_SAVE);

   AST_RISE_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
      $rose(pwr_save) |-> ($past(cnt_w) == CNT_W'(IDLE_CYCLES - 1))); // R2

   AST_DESEL_CLEARS: assert property (@(posedge clk) disable iff (rst)
      !en_w |=> !pwr_save); // R3

   AST_CHG_EXITS: assert property (@(posedge clk) disable iff (rst)
      chg_w |=> !pwr_save); // R4

   AST_LIVE_ON_CHG: assert property (@(posedge clk) disable iff (rst)
      (en_w && chg_w) |-> (out_word == arr_word)); // R4

endmodule

// File: tb/sim_rd_idle_saver.sv
module sim_rd_idle_saver;

   localparam int AW  = 20;
   localparam int DW  = 16;
   localparam int LIM = 20;

   logic          clk = 1'b0;
   logic          rst;
   logic [AW-1:0] addr;
   logic          csel;
   logic [DW-1:0] arr;
   logic          lp;
   logic [DW-1:0] word;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   rd_idle_saver #(
      .ADDR_W(AW), .DATA_W(DW), .IDLE_CYCLES(LIM), .EN_ACTIVE_LOW(1'b0)
   ) u0 (
      .clk(clk), .rst(rst), .rd_addr(addr), .chip_sel(csel),
      .arr_word(arr), .pwr_save(lp), .out_word(word)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #5;
   endtask

   // Drive an address at a falling edge and run to power-save
   task automatic settle(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      addr = a;
      arr  = d;
      edges(LIM + 1);
   endtask

   task automatic t_reset;
      rst = 1'b1; csel = 1'b0; addr = '0; arr = 16'h1111;
      edges(3);
      @(negedge clk);
      rst = 1'b0;
      #2;
      check("R1 flag after reset", 32'(lp), 32'd0);
      check("R1 word deselected", 32'(word), 32'd0);
   endtask

   task automatic t_entry;
      @(negedge clk);
      csel = 1'b1; addr = 20'h00100; arr = 16'hA001;
      edges(LIM);
      check("R8 flag before interval", 32'(lp), 32'd0);
      check("R6 live word", 32'(word), 32'hA001);
      edges(1);
      check("R2 flag at interval", 32'(lp), 32'd1);
   endtask

   task automatic t_interval_edge;
      @(negedge clk);
      addr = 20'h00200; arr = 16'hB002;
      edges(LIM);
      check("R2 flag low one edge early", 32'(lp), 32'd0);
      edges(1);
      check("R2 flag high at limit", 32'(lp), 32'd1);
   endtask

   task automatic t_capture;
      @(negedge clk);
      addr = 20'h00300; arr = 16'hC0C0;
      for (int i = 0; i < LIM; i++) @(posedge clk);
      @(negedge clk);
      arr = 16'hC1C1;
      @(posedge clk);
      #5;
      check("R5 flag at capture", 32'(lp), 32'd1);
      @(negedge clk);
      arr = 16'hDEAD;
      #2;
      check("R5 held word", 32'(word), 32'hC1C1);
      edges(3);
      check("R5 held word stays", 32'(word), 32'hC1C1);
   endtask

   task automatic t_exit_addr;
      @(negedge clk);
      addr = 20'h00301; arr = 16'hE00E;
      #2;
      check("R4 live word on change", 32'(word), 32'hE00E);
      check("R4 flag not yet low", 32'(lp), 32'd1);
      edges(1);
      check("R4 flag low after edge", 32'(lp), 32'd0);
   endtask

   task automatic t_passthrough;
      @(negedge clk);
      arr = 16'h5A5A;
      #2;
      check("R6 follows array", 32'(word), 32'h5A5A);
      @(negedge clk);
      arr = 16'hA5A5;
      #2;
      check("R6 follows array again", 32'(word), 32'hA5A5);
   endtask

   task automatic t_restart;
      settle(20'h00400, 16'h4444);
      @(negedge clk);
      addr = 20'h00401;
      edges(10);
      @(negedge clk);
      addr = 20'h00402;
      edges(LIM);
      check("R7 no early flag after restart", 32'(lp), 32'd0);
      edges(1);
      check("R7 flag after full interval", 32'(lp), 32'd1);
   endtask

   task automatic t_deselect;
      @(negedge clk);
      csel = 1'b0; arr = 16'h7777;
      #2;
      check("R3 word zero deselected", 32'(word), 32'd0);
      edges(1);
      check("R3 flag low deselected", 32'(lp), 32'd0);
      edges(LIM + 5);
      check("R3 flag stays low", 32'(lp), 32'd0);
      @(negedge clk);
      csel = 1'b1;
      edges(LIM);
      check("R8 reselect no early flag", 32'(lp), 32'd0);
      edges(1);
      check("R8 reselect flag", 32'(lp), 32'd1);
   endtask

   task automatic t_bits;
      settle(20'h00000, 16'h0B0B);
      check("R9 setup lsb", 32'(lp), 32'd1);
      @(negedge clk);
      addr = 20'h00001;
      edges(1);
      check("R9 lsb exits", 32'(lp), 32'd0);
      settle(20'h00001, 16'h0C0C);
      check("R9 setup msb", 32'(lp), 32'd1);
      @(negedge clk);
      addr = 20'h80001;
      edges(1);
      check("R9 msb exits", 32'(lp), 32'd0);
   endtask

   initial begin
      #3000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_entry();
      t_interval_edge();
      t_capture();
      t_exit_addr();
      t_passthrough();
      t_restart();
      t_deselect();
      t_bits();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule